// File: doc/BRIEF.md
# Paged word address counter

This block keeps the word address of a 4096-byte memory behind a serial port. A protocol engine loads it with two address bytes taken from a write header. The high byte arrives first and is held in a staging nibble. The low byte arrives second and commits the full 12-bit address. After the load, the counter advances by one for each byte that is accessed. Write-data bytes advance the address only inside the current 32-byte page. Read-data bytes advance it across the whole array.

The counter keeps its value between transactions. A later read that sends no address therefore starts at the byte that follows the last one accessed. The address is also presented as a 7-bit page number and a 5-bit in-page offset, so that page-buffer logic can use the fields directly.

Top module: `word_addr_ctr`

## Requirements
- R1: After reset, the address is 0, and the stored high nibble is 0.
- R2: When the low-byte load strobe is high, the address in the next cycle is {stored high nibble, low byte}. Bits 11:8 come from the high nibble and bits 7:0 from the low byte.
- R3: A high-byte load stores only bits 3:0 of the high byte. Bits 7:4 of that byte never reach the address.
- R4: A high-byte load by itself leaves the address unchanged. Only the later low-byte load uses the stored nibble.
- R5: A write advance adds one to offset bits 4:0, so offset 31 wraps to 0. Page bits 11:5 stay unchanged.
- R6: A read advance adds one to the full 12-bit address, so 4095 wraps to 0.
- R7: In a cycle with no low-byte load and no advance strobe, the address holds its value.
- R8: If more than one strobe is high in the same cycle, the low-byte load wins over both advances, and a write advance wins over a read advance.
- R9: The page output always equals address bits 11:5, and the offset output always equals address bits 4:0.
- R10: If the high-byte and low-byte loads are high in the same cycle, the low-byte load uses the nibble stored before that cycle. The new high nibble is kept for the next low-byte load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| hi_ld_i | input | 1 | Store the high address byte |
| hi_byte_i | input | 8 | High address byte (bits 3:0 are used) |
| lo_ld_i | input | 1 | Load the low address byte and commit the address |
| lo_byte_i | input | 8 | Low address byte |
| wr_adv_i | input | 1 | Advance after a written byte (wraps within the page) |
| rd_adv_i | input | 1 | Advance after a read byte (wraps across the array) |
| addr_o | output | 12 | Current word address |
| page_o | output | 7 | Page number, address bits 11:5 |
| offset_o | output | 5 | In-page offset, address bits 4:0 |

## Verification
A wrong address register shows on addr_o in the cycle after the strobe that caused it, because the outputs come straight from the register. A staging nibble that is wrong stays hidden until the next low-byte load, and then it shows in addr_o bits 11:8. For this reason the bench ends every high-byte load with a low-byte load, and it compares the result in every cycle. A wrong wrap shows at the first advance that crosses offset 31 or address 4095. The bench sets up both boundaries directly and does not wait for random stimulus to reach them.

// File: rtl/wac_pkg.sv
package wac_pkg;
  localparam int PAGE_BITS = 7;
  localparam int OFS_BITS  = 5;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = PAGE_BITS + OFS_BITS;
  localparam int NIB_W     = ADDR_W - BYTE_W;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_WADV = 2'd2,
    ACT_RADV = 2'd3
  } act_e;
endpackage

// File: rtl/wac_rst_sync.sv
module wac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wac_hi_stage.sv
module wac_hi_stage
  import wac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [NIB_W-1:0]  nib_o
);
  logic [NIB_W-1:0] nib_q, nib_d;

  always_comb begin
    nib_d = nib_q;
    if (ld_i) nib_d = byte_i[NIB_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nib_q <= '0;
    else        nib_q <= nib_d;
  end

  assign nib_o = nib_q;
endmodule

// File: rtl/wac_next.sv
module wac_next
  import wac_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NIB_W-1:0]  nib_i,
  input  logic [BYTE_W-1:0] lo_byte_i,
  input  logic              lo_ld_i,
  input  logic              wr_adv_i,
  input  logic              rd_adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              en_o
);
  act_e act;
  logic [OFS_BITS-1:0] ofs_inc;

  always_comb begin
    if (lo_ld_i)       act = ACT_LOAD;
    else if (wr_adv_i) act = ACT_WADV;
    else if (rd_adv_i) act = ACT_RADV;
    else               act = ACT_HOLD;
  end

  assign ofs_inc = addr_i[OFS_BITS-1:0] + 1'b1;

  always_comb begin
    unique case (act)
      ACT_LOAD: addr_o = {nib_i, lo_byte_i};
      ACT_WADV: addr_o = {addr_i[ADDR_W-1:OFS_BITS], ofs_inc};
      ACT_RADV: addr_o = addr_i + 1'b1;
      default:  addr_o = addr_i;
    endcase
  end

  assign en_o = (act != ACT_HOLD);
endmodule

// File: rtl/word_addr_ctr.sv
module word_addr_ctr
  import wac_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hi_ld_i,
  input  logic [BYTE_W-1:0]    hi_byte_i,
  input  logic                 lo_ld_i,
  input  logic [BYTE_W-1:0]    lo_byte_i,
  input  logic                 wr_adv_i,
  input  logic                 rd_adv_i,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [PAGE_BITS-1:0] page_o,
  output logic [OFS_BITS-1:0]  offset_o
);
  logic              rst_sync_n;
  logic [NIB_W-1:0]  nib;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  wac_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  wac_hi_stage u_hi (
    .clk(clk), .rst_n(rst_sync_n), .ld_i(hi_ld_i),
    .byte_i(hi_byte_i), .nib_o(nib)
  );

  wac_next u_next (
    .addr_i(addr_q), .nib_i(nib), .lo_byte_i(lo_byte_i),
    .lo_ld_i(lo_ld_i), .wr_adv_i(wr_adv_i), .rd_adv_i(rd_adv_i),
    .addr_o(addr_d), .en_o(addr_en)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o   = addr_q;
  assign page_o   = addr_q[ADDR_W-1:OFS_BITS];
  assign offset_o = addr_q[OFS_BITS-1:0];
endmodule

// File: rtl/word_addr_ctr_checks.sv
module word_addr_ctr_checks
  import wac_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hi_ld_i,
  input logic                 lo_ld_i,
  input logic [BYTE_W-1:0]    lo_byte_i,
  input logic                 wr_adv_i,
  input logic                 rd_adv_i,
  input logic [ADDR_W-1:0]    addr_o,
  input logic [PAGE_BITS-1:0] page_o,
  input logic [OFS_BITS-1:0]  offset_o
);
  a_r2_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
    lo_ld_i |=> addr_o[BYTE_W-1:0] == $past(lo_byte_i));

  a_r4_hi_only_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_ld_i && !lo_ld_i && !wr_adv_i && !rd_adv_i) |=> $stable(addr_o));

  a_r5_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_adv_i && !lo_ld_i) |=> (page_o == $past(page_o)) &&
      (offset_o == $past(offset_o) + 5'd1));

  a_r6_full_step: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_adv_i && !wr_adv_i && !lo_ld_i) |=> addr_o == $past(addr_o) + 12'd1);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_ld_i && !wr_adv_i && !rd_adv_i) |=> $stable(addr_o));
endmodule

bind word_addr_ctr word_addr_ctr_checks u_checks (
  .clk(clk), .rst_n(rst_sync_n), .hi_ld_i(hi_ld_i), .lo_ld_i(lo_ld_i),
  .lo_byte_i(lo_byte_i), .wr_adv_i(wr_adv_i), .rd_adv_i(rd_adv_i),
  .addr_o(addr_o), .page_o(page_o), .offset_o(offset_o)
);

// File: tb/word_addr_ctr_tb.sv
module word_addr_ctr_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic hi_ld, lo_ld, wr_adv, rd_adv;
  logic [7:0] hi_byte, lo_byte;
  logic [11:0] addr;
  logic [6:0] page;
  logic [4:0] offset;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [11:0] m_addr;
  logic [3:0]  m_nib;

  always #(CLK_PERIOD/2) clk = ~clk;

  word_addr_ctr u_dut (
    .clk(clk), .rst_n(rst_n), .hi_ld_i(hi_ld), .hi_byte_i(hi_byte),
    .lo_ld_i(lo_ld), .lo_byte_i(lo_byte), .wr_adv_i(wr_adv), .rd_adv_i(rd_adv),
    .addr_o(addr), .page_o(page), .offset_o(offset)
  );

  function automatic logic [11:0] model_next(logic [11:0] a, logic [3:0] n,
      logic ll, logic [7:0] lb, logic w, logic r);
    if (ll)     return {n, lb};
    else if (w) return {a[11:5], a[4:0] + 5'd1};
    else if (r) return a + 12'd1;
    else        return a;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic hl, logic [7:0] hb, logic ll, logic [7:0] lb,
      logic w, logic r, string tag);
    logic [11:0] exp;
    hi_ld = hl; hi_byte = hb; lo_ld = ll; lo_byte = lb; wr_adv = w; rd_adv = r;
    exp = model_next(m_addr, m_nib, ll, lb, w, r);
    if (hl) m_nib = hb[3:0];
    m_addr = exp;
    @(negedge clk);
    chk(addr == exp, tag, addr, exp);
    chk(page == exp[11:5] && offset == exp[4:0], "R9", {page, offset}, exp);
  endtask

  task automatic load(logic [7:0] hb, logic [7:0] lb);
    step(1'b1, hb, 1'b0, 8'h00, 1'b0, 1'b0, "R4");
    step(1'b0, 8'h00, 1'b1, lb, 1'b0, 1'b0, "R2");
  endtask

  initial begin
    rst_n = 1'b0; hi_ld = 0; lo_ld = 0; wr_adv = 0; rd_adv = 0;
    hi_byte = 0; lo_byte = 0;
    m_addr = 0; m_nib = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(addr == 12'h000, "R1", addr, 0);
    step(1'b0, 8'h00, 1'b1, 8'h55, 1'b0, 1'b0, "R1");
    // R3: upper nibble of high byte must vanish
    load(8'hF3, 8'h7E);
    chk(addr == 12'h37E, "R3", addr, 12'h37E);
    // R5: offset 31 wraps inside page
    load(8'h03, 8'hFF);
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b0, "R5");
    chk(addr == 12'h3E0, "R5", addr, 12'h3E0);
    // R6: end of array wraps to 0
    load(8'h0F, 8'hFF);
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, "R6");
    chk(addr == 12'h000, "R6", addr, 0);
    // R7: idle hold
    step(1'b0, 8'hAA, 1'b0, 8'hBB, 1'b0, 1'b0, "R7");
    // R8: load beats advances, write beats read
    load(8'h02, 8'h1F);
    step(1'b0, 8'h00, 1'b1, 8'h40, 1'b1, 1'b1, "R8");
    chk(addr == 12'h240, "R8", addr, 12'h240);
    load(8'h05, 8'hBF);
    step(1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, "R8");
    chk(addr == 12'h5A0, "R8", addr, 12'h5A0);
    // R10: simultaneous loads use the old nibble, keep the new one
    load(8'h06, 8'h00);
    step(1'b1, 8'h09, 1'b1, 8'h12, 1'b0, 1'b0, "R10");
    chk(addr == 12'h612, "R10", addr, 12'h612);
    step(1'b0, 8'h00, 1'b1, 8'h34, 1'b0, 1'b0, "R10");
    chk(addr == 12'h934, "R10", addr, 12'h934);
    // random mix
    void'($urandom(32'd20511));
    for (int i = 0; i < 3000; i++) begin
      logic hl, ll, w, r;
      string tag;
      hl = ($urandom % 5) == 0;
      ll = ($urandom % 6) == 0;
      w  = ($urandom % 3) == 0;
      r  = ($urandom % 3) == 0;
      if (ll && hl)  tag = "R10";
      else if (ll)   tag = (w || r) ? "R8" : "R2";
      else if (w)    tag = r ? "R8" : "R5";
      else if (r)    tag = "R6";
      else if (hl)   tag = "R4";
      else           tag = "R7";
      step(hl, 8'($urandom), ll, 8'($urandom), w, r, tag);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule